// File: doc/BRIEF.md
# Instruction Bundle Slot Dispersal Unit

This block takes a 128-bit instruction bundle and breaks it into single instructions. Each bundle holds three 41-bit instruction slots and a 5-bit template code. The block accepts one bundle over a valid/ready handshake and stores it. It then presents the bundle's instructions downstream one beat at a time, on a second valid/ready handshake.

The template code alone sets two things for each slot: its basic instruction type, and the execution unit classes that may run it. A slot's opcode bits are never consulted for this. The same code also marks where instruction groups end. A group boundary can fall at the end of the bundle or, for four codes, between two slots, so each beat carries its own end-of-group flag. In the long-immediate format, the last two slots are merged into one beat that carries a 64-bit immediate. A bundle whose template code is reserved is consumed, produces no beats and raises a one-cycle error.

Top module: `bundle_disperser`

## Requirements
- R1: Bundle bit layout is template [4:0], slot 0 [45:5], slot 1 [86:46], slot 2 [127:87]. `inReady` is high exactly when no bundle is held, and a bundle is taken on a cycle with `inValid` and `inReady` both high.
- R2: A held bundle is emitted as one beat per accepted output cycle, in slot order 0, 1, 2. `outIdx` gives the slot number. `outValid` first rises with `outIdx` = 0 and falls after the last beat is taken.
- R3: While `outValid` is high and `outReady` is low, every output field holds its value.
- R4: `outType` comes only from the template (bits [4:1]) and the slot position. The type codes are M=0, I=1, F=2, B=3 and long=4. The formats are: 0/1 MII, 2/3 MII, 4/5 M+long, 8/9 MMI, 10/11 MMI, 12/13 MFI, 14/15 MMF, 16/17 MIB, 18/19 MBB, 22/23 BBB, 24/25 MMB and 28/29 MFB.
- R5: `outUnits` is a unit-class mask with bit0 = integer, bit1 = memory, bit2 = floating point and bit3 = branch. Type M maps to memory, I to integer, F to floating point and B to branch. The long type maps to integer.
- R6: The beat that carries the last slot of the bundle has `outEog` equal to template bit 0.
- R7: Templates 2 and 3 set `outEog` on slot 1. Templates 10 and 11 set `outEog` on slot 0. In every other case, a beat that is not the last beat has `outEog` low.
- R8: Templates 4 and 5 give two beats. The second beat has `outIdx` = 1, type long and `outSlot` = slot 2, and `outLongImm` = {slot 1, slot 2[22:0]}. On every other beat, `outLongImm` is zero.
- R9: Reserved templates are 6, 7, 20, 21, 26, 27, 30 and 31. Such a bundle is consumed without emitting any beat. `errIllegal` is high for exactly the one cycle after it is taken, and `inReady` stays high.
- R10: A synchronous reset drops any held bundle, which leaves `outValid` and `errIllegal` low and `inReady` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Upstream bundle valid |
| inReady | output | 1 | Block can take a bundle |
| inBundle | input | 128 | Instruction bundle |
| outValid | output | 1 | Instruction beat valid |
| outReady | input | 1 | Downstream takes the beat |
| outSlot | output | 41 | Raw slot contents |
| outIdx | output | 2 | Slot number of the beat |
| outType | output | 3 | Basic instruction type |
| outUnits | output | 4 | Allowed execution unit classes |
| outEog | output | 1 | Instruction group ends after this beat |
| outLongImm | output | 64 | Merged immediate on a long beat |
| errIllegal | output | 1 | Reserved template was consumed |

## Verification
All 32 template codes are sent once with no downstream stall. This separates the twelve slot-type formats, the four codes that carry an inner stop and the eight reserved codes. A second pass repeats the codes with random `outReady` stalls, so each beat is checked while held as well as when it is taken. Random bundles follow, with random payloads and random template codes. Because a reserved code turns up often among them, an error bundle regularly sits between two good ones. A payload that is the same in every slot shows whether type and unit follow the position rather than the bits, and a reset in the middle of a bundle shows that held state is dropped.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int SLOT_W   = 41;
  localparam int TMPL_W   = 5;
  localparam int NSLOTS   = 3;
  localparam int BUNDLE_W = TMPL_W + NSLOTS * SLOT_W;
  localparam int IMM_W    = 64;
  localparam int IMM_LO_W = IMM_W - SLOT_W;
  localparam int UNIT_W   = 4;
  localparam int IDX_W    = 2;

  typedef enum logic [2:0] {
    TY_M = 3'd0, TY_I = 3'd1, TY_F = 3'd2, TY_B = 3'd3, TY_L = 3'd4
  } slotType_e;

  typedef struct packed {
    logic load;
    logic advance;
    logic flagErr;
  } ctrlStrobes_t;

  function automatic logic tmplReserved(input logic [TMPL_W-1:0] t);
    case (t[4:1])
      4'd3, 4'd10, 4'd13, 4'd15: return 1'b1;
      default:                   return 1'b0;
    endcase
  endfunction

  function automatic slotType_e tmplSlotType(input logic [TMPL_W-1:0] t,
                                             input logic [IDX_W-1:0] pos);
    slotType_e f0, f1, f2;
    f0 = TY_M; f1 = TY_I; f2 = TY_I;
    case (t[4:1])
      4'd2:         begin f1 = TY_L; f2 = TY_L; end
      4'd4, 4'd5:   begin f1 = TY_M; end
      4'd6:         begin f1 = TY_F; end
      4'd7:         begin f1 = TY_M; f2 = TY_F; end
      4'd8:         begin f2 = TY_B; end
      4'd9:         begin f1 = TY_B; f2 = TY_B; end
      4'd11:        begin f0 = TY_B; f1 = TY_B; f2 = TY_B; end
      4'd12:        begin f1 = TY_M; f2 = TY_B; end
      4'd14:        begin f1 = TY_F; f2 = TY_B; end
      default:      ;
    endcase
    case (pos)
      2'd0:    return f0;
      2'd1:    return f1;
      default: return f2;
    endcase
  endfunction

  function automatic logic [UNIT_W-1:0] unitMask(input slotType_e ty);
    case (ty)
      TY_M:    return 4'b0010;
      TY_F:    return 4'b0100;
      TY_B:    return 4'b1000;
      default: return 4'b0001;
    endcase
  endfunction

  function automatic logic tmplStopAfter(input logic [TMPL_W-1:0] t,
                                         input logic [IDX_W-1:0] pos,
                                         input logic lastBeat);
    if (lastBeat)       return t[0];
    else if (pos == 2'd1) return t[4:1] == 4'd1;
    else                return t[4:1] == 4'd5;
  endfunction
endpackage

// File: rtl/disp_ctrl.sv
module disp_ctrl
  import disp_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         outReady,
  input  logic         inReserved,
  input  logic         lastBeat,
  output logic         busy,
  output logic         errPulse,
  output ctrlStrobes_t strb
);
  logic busyQ, errQ, finish;

  always_comb begin
    strb.load    = inValid && !busyQ && !inReserved;
    strb.flagErr = inValid && !busyQ && inReserved;
    strb.advance = busyQ && outReady && !lastBeat;
    finish       = busyQ && outReady && lastBeat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busyQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      errQ <= strb.flagErr;
      if (strb.load)   busyQ <= 1'b1;
      else if (finish) busyQ <= 1'b0;
    end
  end

  assign busy     = busyQ;
  assign errPulse = errQ;
endmodule

// File: rtl/disp_data.sv
module disp_data
  import disp_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobes_t        strb,
  input  logic [BUNDLE_W-1:0] inBundle,
  output logic                inReserved,
  output logic                lastBeat,
  output logic [SLOT_W-1:0]   outSlot,
  output logic [IDX_W-1:0]    outIdx,
  output slotType_e           outType,
  output logic [UNIT_W-1:0]   outUnits,
  output logic                outEog,
  output logic [IMM_W-1:0]    outLongImm
);
  logic [BUNDLE_W-1:0] bundleQ;
  logic [IDX_W-1:0]    idxQ;
  logic [SLOT_W-1:0]   slots [NSLOTS];
  logic [TMPL_W-1:0]   tmpl;
  logic                isLong;

  for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
    assign slots[s] = bundleQ[TMPL_W + s*SLOT_W +: SLOT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bundleQ <= '0;
      idxQ    <= '0;
    end else if (strb.load) begin
      bundleQ <= inBundle;
      idxQ    <= '0;
    end else if (strb.advance) begin
      idxQ    <= idxQ + 1'b1;
    end
  end

  always_comb begin
    tmpl       = bundleQ[TMPL_W-1:0];
    inReserved = tmplReserved(inBundle[TMPL_W-1:0]);
    outType    = tmplSlotType(tmpl, idxQ);
    isLong     = (outType == TY_L);
    lastBeat   = (idxQ == 2'd2) || isLong;
    outUnits   = unitMask(outType);
    outEog     = tmplStopAfter(tmpl, idxQ, lastBeat);
    outIdx     = idxQ;
    case (idxQ)
      2'd0:    outSlot = slots[0];
      2'd1:    outSlot = isLong ? slots[2] : slots[1];
      default: outSlot = slots[2];
    endcase
    outLongImm = isLong ? {slots[1], slots[2][IMM_LO_W-1:0]} : '0;
  end
endmodule

// File: rtl/bundle_disperser.sv
module bundle_disperser
  import disp_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  output logic                inReady,
  input  logic [BUNDLE_W-1:0] inBundle,
  output logic                outValid,
  input  logic                outReady,
  output logic [SLOT_W-1:0]   outSlot,
  output logic [IDX_W-1:0]    outIdx,
  output logic [2:0]          outType,
  output logic [UNIT_W-1:0]   outUnits,
  output logic                outEog,
  output logic [IMM_W-1:0]    outLongImm,
  output logic                errIllegal
);
  ctrlStrobes_t strb;
  logic         inReserved, lastBeat, busy;
  slotType_e    typeW;

  disp_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .outReady(outReady),
    .inReserved(inReserved), .lastBeat(lastBeat), .busy(busy),
    .errPulse(errIllegal), .strb(strb)
  );

  disp_data u_data (
    .clk(clk), .rst(rst), .strb(strb), .inBundle(inBundle),
    .inReserved(inReserved), .lastBeat(lastBeat), .outSlot(outSlot),
    .outIdx(outIdx), .outType(typeW), .outUnits(outUnits),
    .outEog(outEog), .outLongImm(outLongImm)
  );

  assign outValid = busy;
  assign inReady  = !busy;
  assign outType  = typeW;
endmodule

// File: rtl/disp_checker.sv
module disp_checker
  import disp_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                inValid,
  input logic                inReady,
  input logic [BUNDLE_W-1:0] inBundle,
  input logic                outValid,
  input logic                outReady,
  input logic [SLOT_W-1:0]   outSlot,
  input logic [IDX_W-1:0]    outIdx,
  input logic [2:0]          outType,
  input logic [UNIT_W-1:0]   outUnits,
  input logic                outEog,
  input logic [IMM_W-1:0]    outLongImm,
  input logic                errIllegal
);
  a_r1_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !inReady);

  a_r2_first_slot: assert property (@(posedge clk) disable iff (rst)
    $rose(outValid) |-> outIdx == 2'd0);

  a_r2_slot_order: assert property (@(posedge clk) disable iff (rst)
    outValid && outReady && outIdx == 2'd0 |=> outValid && outIdx == 2'd1);

  a_r3_hold_stable: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outSlot) && $stable(outIdx)
      && $stable(outType) && $stable(outEog) && $stable(outLongImm));

  a_r8_long_position: assert property (@(posedge clk) disable iff (rst)
    outValid && outType == 3'd4 |-> outIdx == 2'd1 && outUnits == 4'b0001);

  a_r9_err_pulse: assert property (@(posedge clk) disable iff (rst)
    inValid && inReady && tmplReserved(inBundle[TMPL_W-1:0])
      |=> errIllegal && !outValid);

  a_r9_err_single: assert property (@(posedge clk) disable iff (rst)
    errIllegal |=> !errIllegal || $past(inValid && inReady));
endmodule

bind bundle_disperser disp_checker u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .inBundle(inBundle), .outValid(outValid), .outReady(outReady),
  .outSlot(outSlot), .outIdx(outIdx), .outType(outType),
  .outUnits(outUnits), .outEog(outEog), .outLongImm(outLongImm),
  .errIllegal(errIllegal)
);

// File: tb/sim_bundle_disperser.sv
`timescale 1ns/1ps
module sim_bundle_disperser;
  localparam int TM = 0, TI = 1, TF = 2, TB = 3, TL = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [127:0] inBundle = '0;
  logic         outValid;
  logic         outReady = 1'b0;
  logic [40:0]  outSlot;
  logic [1:0]   outIdx;
  logic [2:0]   outType;
  logic [3:0]   outUnits;
  logic         outEog;
  logic [63:0]  outLongImm;
  logic         errIllegal;
  int           total = 0;
  int           bad = 0;

  always #4 clk = ~clk;

  bundle_disperser u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inBundle(inBundle), .outValid(outValid), .outReady(outReady),
    .outSlot(outSlot), .outIdx(outIdx), .outType(outType),
    .outUnits(outUnits), .outEog(outEog), .outLongImm(outLongImm),
    .errIllegal(errIllegal)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit isReserved(input logic [4:0] t);
    return t == 6 || t == 7 || t == 20 || t == 21 || t == 26 || t == 27
        || t == 30 || t == 31;
  endfunction

  function automatic int expType(input logic [4:0] t, input int pos);
    int f [3];
    case (t)
      5'd0, 5'd1, 5'd2, 5'd3:     f = '{TM, TI, TI};
      5'd4, 5'd5:                 f = '{TM, TL, TL};
      5'd8, 5'd9, 5'd10, 5'd11:   f = '{TM, TM, TI};
      5'd12, 5'd13:               f = '{TM, TF, TI};
      5'd14, 5'd15:               f = '{TM, TM, TF};
      5'd16, 5'd17:               f = '{TM, TI, TB};
      5'd18, 5'd19:               f = '{TM, TB, TB};
      5'd22, 5'd23:               f = '{TB, TB, TB};
      5'd24, 5'd25:               f = '{TM, TM, TB};
      5'd28, 5'd29:               f = '{TM, TF, TB};
      default:                    f = '{TM, TM, TM};
    endcase
    return f[pos];
  endfunction

  function automatic logic [3:0] expUnits(input int ty);
    case (ty)
      TM: return 4'b0010;
      TF: return 4'b0100;
      TB: return 4'b1000;
      default: return 4'b0001;
    endcase
  endfunction

  task automatic checkBeat(input logic [127:0] b, input int k, input bit held);
    logic [4:0]  t;
    logic [40:0] s0, s1, s2, eSlot;
    logic [63:0] eImm;
    bit          lng, last, eEog;
    int          ty;
    t  = b[4:0];
    s0 = b[45:5]; s1 = b[86:46]; s2 = b[127:87];
    lng  = (t == 4 || t == 5) && k == 1;
    last = (k == 2) || lng;
    ty   = expType(t, k);
    if (last)        eEog = t[0];
    else if (k == 1) eEog = (t == 2 || t == 3);
    else             eEog = (t == 10 || t == 11);
    eSlot = (k == 0) ? s0 : (k == 1 && !lng) ? s1 : s2;
    eImm  = lng ? {s1, s2[22:0]} : 64'd0;
    check(outValid == 1'b1, held ? "R3 valid" : "R2 valid", 64'(outValid), 64'd1);
    check(inReady == 1'b0, "R1 ready while busy", 64'(inReady), 64'd0);
    check(outIdx == 2'(k), held ? "R3 idx" : "R2 idx", 64'(outIdx), 64'(k));
    check(outType == 3'(ty), lng ? "R8 type" : "R4 type", 64'(outType), 64'(ty));
    check(outUnits == expUnits(ty), "R5 units", 64'(outUnits), 64'(expUnits(ty)));
    check(outEog == eEog, last ? "R6 eog" : "R7 eog", 64'(outEog), 64'(eEog));
    check(outSlot == eSlot, held ? "R3 slot" : "R2 slot", 64'(outSlot), 64'(eSlot));
    check(outLongImm == eImm, "R8 imm", outLongImm, eImm);
  endtask

  task automatic runBundle(input logic [127:0] b, input int maxStall);
    int nb;
    @(negedge clk);
    check(inReady == 1'b1, "R1 ready when idle", 64'(inReady), 64'd1);
    inValid = 1'b1; inBundle = b;
    @(negedge clk);
    inValid = 1'b0;
    if (isReserved(b[4:0])) begin
      check(errIllegal == 1'b1, "R9 err raised", 64'(errIllegal), 64'd1);
      check(outValid == 1'b0, "R9 no beat", 64'(outValid), 64'd0);
      check(inReady == 1'b1, "R9 ready kept", 64'(inReady), 64'd1);
      @(negedge clk);
      check(errIllegal == 1'b0, "R9 err one cycle", 64'(errIllegal), 64'd0);
      return;
    end
    nb = (b[4:0] == 4 || b[4:0] == 5) ? 2 : 3;
    for (int k = 0; k < nb; k++) begin
      int stall;
      stall = (maxStall > 0) ? int'($urandom_range(maxStall, 0)) : 0;
      for (int s = 0; s <= stall; s++) begin
        if (s == stall) outReady = 1'b1;
        checkBeat(b, k, s > 0);
        @(negedge clk);
      end
      outReady = 1'b0;
    end
    check(outValid == 1'b0, "R2 done", 64'(outValid), 64'd0);
  endtask

  function automatic logic [127:0] randBundle(input logic [4:0] t);
    logic [127:0] b;
    b = {$urandom, $urandom, $urandom, $urandom};
    b[4:0] = t;
    return b;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R10 reset valid", 64'(outValid), 64'd0);
    check(inReady == 1'b1, "R10 reset ready", 64'(inReady), 64'd1);
    check(errIllegal == 1'b0, "R10 reset err", 64'(errIllegal), 64'd0);

    for (int t = 0; t < 32; t++) runBundle(randBundle(5'(t)), 0);
    for (int t = 0; t < 32; t++) runBundle(randBundle(5'(t)), 2);
    // identical payload in every slot: type must come from position (R4)
    runBundle({{3{41'h155_5555_5555}}, 5'd28}, 1);
    runBundle({{3{41'h0AA_AAAA_AAAA}}, 5'd5}, 1);
    runBundle(randBundle(5'd7), 0);
    runBundle(randBundle(5'd11), 0);

    // reset mid bundle (R10)
    @(negedge clk);
    inValid = 1'b1; inBundle = randBundle(5'd16);
    @(negedge clk);
    inValid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(outValid == 1'b0, "R10 mid reset valid", 64'(outValid), 64'd0);
    check(inReady == 1'b1, "R10 mid reset ready", 64'(inReady), 64'd1);

    for (int n = 0; n < 300; n++) runBundle(randBundle(5'($urandom_range(31, 0))), 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule